// File: doc/BRIEF.md
# Multiplierless Gaussian Pulse Shaper

This block shapes a stream of signed samples with an approximately Gaussian impulse response. A typical input is an oversampled stream of +1/-1 symbols ahead of a frequency modulator. The shaping comes from a cascade of moving-sum (boxcar) stages. Each time a boxcar response is convolved with another, the combined response moves closer to a bell shape. Four stages of unequal length, 3 and 5 repeated, give a usable approximation.

Each stage is built in recursive form. A wrap-around accumulator feeds a difference against the accumulator value from L samples earlier. A stage therefore costs one adder, one subtractor and an L-deep delay line, and the cascade has no multiplier anywhere.

All internal registers share one word width: the input width plus the sum of ceil(log2 L) over the stages. Because this width covers the DC gain, the output is exact even when the accumulators overflow. An optional right shift drops a fixed number of LSBs at the output. The block does not change the sample rate, and it advances only on samples marked valid.

Top module: `gauss_shaper`

## Requirements
- R1: A synchronous reset drives out_vld and out_smp to 0 and clears every accumulator and delay line. The first impulse after reset yields exactly the clean impulse response, even when samples were in flight at reset.
- R2: With no truncation, output sample n equals the sum over k of h[k]·x[n−k]. Here h is the convolution of the configured boxcars; for stage lengths 3,5,3,5 it is the 13-tap sequence 1,4,10,18,27,34,37,34,27,18,10,4,1. Samples before reset count as zero.
- R3: out_vld is in_vld delayed by exactly N_STAGES clock cycles: 4 cycles for four stages, 2 cycles for two.
- R4: The filter advances only on in_vld. Idle cycles between samples do not change the output sequence, every accepted sample produces exactly one output, and out_smp holds its value whenever out_vld is low.
- R5: The DC gain is the product of the stage lengths. A constant input c settles to c·prod, shifted right by TRUNC_LSB, and no output ever exceeds the input range times that gain.
- R6: Full-scale input streams (all −2^(IN_W−1), all 2^(IN_W−1)−1, or the two alternating) give exact results despite accumulator wrap-around.
- R7: With TRUNC_LSB = T, out_smp is the full-precision result shifted right arithmetically by T (a floor), so a full result of −1 or −2 with T=3 reads as −1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks in_smp as a new sample |
| in_smp | input | IN_W | Signed input sample |
| out_vld | output | 1 | Marks out_smp as a new shaped sample |
| out_smp | output | OUT_W | Signed shaped sample, FULL_W − TRUNC_LSB bits |

## Verification
The bench builds two instances side by side on the same stimulus. The first uses the default four stages of lengths 3,5,3,5 with no truncation, which exposes the exact 13-tap response, the 225× gain and the four-cycle latency. The second uses two stages of lengths 2 and 16 with a three-bit output shift, which reaches the longest permitted delay line, a non-power-of-two word growth and floor rounding of negative results. Every output of both is compared with a direct convolution that the bench computes from the stage lengths alone.

// File: rtl/gshape_pkg.sv
package gshape_pkg;

   localparam int unsigned MAX_STAGES = 4;
   localparam int unsigned MIN_LEN    = 2;
   localparam int unsigned MAX_LEN    = 16;

   typedef int unsigned len_arr_t [MAX_STAGES];

   // extra bits needed so the cascade gain fits in the word
   function automatic int unsigned growth_bits(len_arr_t lens, int unsigned n);
      int unsigned acc;
      acc = 0;
      for (int i = 0; i < int'(n); i++) acc += $clog2(lens[i]);
      return acc;
   endfunction

   // product of the stage lengths
   function automatic longint dc_gain(len_arr_t lens, int unsigned n);
      longint g;
      g = 1;
      for (int i = 0; i < int'(n); i++) g *= longint'(lens[i]);
      return g;
   endfunction

endpackage

// File: rtl/boxcar_integ.sv
module boxcar_integ #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] x,
   output logic [W-1:0] sum_nxt
);
   logic [W-1:0] acc_q;

   // modulo-2^W running sum; wrap is harmless since the comb cancels it
   assign sum_nxt = acc_q + x;

   always_ff @(posedge clk) begin
      if (rst)     acc_q <= '0;
      else if (en) acc_q <= sum_nxt;
   end
endmodule

// File: rtl/boxcar_comb.sv
module boxcar_comb #(
   parameter int unsigned W = 16,
   parameter int unsigned L = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] integ,
   output logic [W-1:0] y,
   output logic         y_vld
);
   logic [W-1:0] dly_q [L];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(L); i++) dly_q[i] <= '0;
         y     <= '0;
         y_vld <= 1'b0;
      end else begin
         y_vld <= en;
         if (en) begin
            y        <= integ - dly_q[L-1];
            dly_q[0] <= integ;
            for (int i = 1; i < int'(L); i++) dly_q[i] <= dly_q[i-1];
         end
      end
   end
endmodule

// File: rtl/boxcar_stage.sv
module boxcar_stage #(
   parameter int unsigned W = 16,
   parameter int unsigned L = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         i_vld,
   input  logic [W-1:0] i_dat,
   output logic         o_vld,
   output logic [W-1:0] o_dat
);
   logic [W-1:0] integ_w;

   boxcar_integ #(.W(W)) u_integ (
      .clk     (clk),
      .rst     (rst),
      .en      (i_vld),
      .x       (i_dat),
      .sum_nxt (integ_w)
   );

   boxcar_comb #(.W(W), .L(L)) u_comb (
      .clk   (clk),
      .rst   (rst),
      .en    (i_vld),
      .integ (integ_w),
      .y     (o_dat),
      .y_vld (o_vld)
   );
endmodule

// File: rtl/out_trunc.sv
module out_trunc #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned SHIFT = 0,
   localparam int unsigned O_W  = IN_W - SHIFT
) (
   input  logic [IN_W-1:0] d,
   output logic [O_W-1:0]  q
);
   generate
      if (SHIFT == 0) begin : g_pass
         assign q = d;
      end else begin : g_drop
         // dropping LSBs of a two's complement word is a floor division
         assign q = d[IN_W-1:SHIFT];
      end
   endgenerate
endmodule

// File: rtl/gauss_shaper.sv
module gauss_shaper
   import gshape_pkg::*;
#(
   parameter int unsigned IN_W      = 8,
   parameter int unsigned N_STAGES  = 4,
   parameter len_arr_t    LEN       = '{3, 5, 3, 5},
   parameter int unsigned TRUNC_LSB = 0,
   localparam int unsigned FULL_W   = IN_W + growth_bits(LEN, N_STAGES),
   localparam int unsigned OUT_W    = FULL_W - TRUNC_LSB
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [IN_W-1:0]  in_smp,
   output logic             out_vld,
   output logic [OUT_W-1:0] out_smp
);

   // elaboration-time legality checks
   generate
      if (N_STAGES < 2 || N_STAGES > MAX_STAGES) begin : g_bad_n
         $error("gauss_shaper: N_STAGES out of range");
      end
      if (IN_W < 2) begin : g_bad_w
         $error("gauss_shaper: IN_W too small");
      end
      if (TRUNC_LSB >= FULL_W) begin : g_bad_t
         $error("gauss_shaper: TRUNC_LSB leaves no output bits");
      end
      for (genvar c = 0; c < int'(N_STAGES); c++) begin : g_len_chk
         if (LEN[c] < MIN_LEN || LEN[c] > MAX_LEN) begin : g_bad_l
            $error("gauss_shaper: stage length out of range");
         end
      end
   endgenerate

   logic [FULL_W-1:0] dat [N_STAGES+1];
   logic              vld [N_STAGES+1];

   assign dat[0] = FULL_W'($signed(in_smp));
   assign vld[0] = in_vld;

   generate
      for (genvar s = 0; s < int'(N_STAGES); s++) begin : g_stage
         boxcar_stage #(.W(FULL_W), .L(LEN[s])) u_stg (
            .clk   (clk),
            .rst   (rst),
            .i_vld (vld[s]),
            .i_dat (dat[s]),
            .o_vld (vld[s+1]),
            .o_dat (dat[s+1])
         );
      end
   endgenerate

   out_trunc #(.IN_W(FULL_W), .SHIFT(TRUNC_LSB)) u_trunc (
      .d (dat[N_STAGES]),
      .q (out_smp)
   );

   assign out_vld = vld[N_STAGES];

endmodule

// File: rtl/gauss_shaper_chk.sv
module gauss_shaper_chk
   import gshape_pkg::*;
#(
   parameter int unsigned IN_W      = 8,
   parameter int unsigned N_STAGES  = 4,
   parameter len_arr_t    LEN       = '{3, 5, 3, 5},
   parameter int unsigned TRUNC_LSB = 0,
   parameter int unsigned OUT_W     = 18
) (
   input logic             clk,
   input logic             rst,
   input logic             in_vld,
   input logic             out_vld,
   input logic [OUT_W-1:0] out_smp
);
   localparam longint GAIN = dc_gain(LEN, N_STAGES);
   localparam longint HI   = (GAIN * ((longint'(1) <<< (IN_W-1)) - 1)) >>> TRUNC_LSB;
   localparam longint LO   = (-(GAIN * (longint'(1) <<< (IN_W-1)))) >>> TRUNC_LSB;

   logic [MAX_STAGES-1:0] vld_hist_q;

   always_ff @(posedge clk) begin
      if (rst) vld_hist_q <= '0;
      else     vld_hist_q <= {vld_hist_q[MAX_STAGES-2:0], in_vld};
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && out_smp == '0));

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld == vld_hist_q[N_STAGES-1]);

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_smp) |-> out_vld);

   // R5
   gain_bound_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (longint'($signed(out_smp)) <= HI &&
                   longint'($signed(out_smp)) >= LO));
endmodule

bind gauss_shaper gauss_shaper_chk #(
   .IN_W      (IN_W),
   .N_STAGES  (N_STAGES),
   .LEN       (LEN),
   .TRUNC_LSB (TRUNC_LSB),
   .OUT_W     (OUT_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .in_vld  (in_vld),
   .out_vld (out_vld),
   .out_smp (out_smp)
);

// File: tb/sim_gauss_shaper.sv
`timescale 1ns/1ps
module sim_gauss_shaper;

   // impulse input and hand-derived taps of the 3,5,3,5 cascade (R2)
   localparam int TBL_N = 16;
   localparam int TBL_IN  [TBL_N] = '{1,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};
   localparam int TBL_EXP [TBL_N] = '{1,4,10,18,27,34,37,34,27,18,10,4,1,0,0,0};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [7:0]  in_smp = '0;
   logic        out_vld0, out_vld1;
   logic [17:0] out0;
   logic [9:0]  out1;

   always #2 clk = ~clk;

   gauss_shaper u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
      .out_vld(out_vld0), .out_smp(out0));

   gauss_shaper #(.IN_W(8), .N_STAGES(2), .LEN('{2, 16, 2, 2}), .TRUNC_LSB(3)) u1 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
      .out_vld(out_vld1), .out_smp(out1));

   int n_tests = 0;
   int n_fail  = 0;
   int hist [1024];
   int nidx = 0, oidx0 = 0, oidx1 = 0;
   int taps0 [64], taps1 [64];
   int nt0, nt1;
   int got0 [64];
   int last0 = 0, last1 = 0;
   logic [17:0] prev0 = '0;
   logic [9:0]  prev1 = '0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic mk_taps(input int lens [4], input int n, output int t [64], output int tn);
      int tmp [64];
      t = '{default: 0};
      t[0] = 1;
      tn = 1;
      for (int s = 0; s < n; s++) begin
         tmp = '{default: 0};
         for (int k = 0; k < tn + lens[s] - 1; k++)
            for (int j = 0; j < lens[s]; j++)
               if (k - j >= 0 && k - j < tn) tmp[k] += t[k-j];
         t = tmp;
         tn += lens[s] - 1;
      end
   endtask

   function automatic int model(input int which, input int n);
      int acc;
      acc = 0;
      if (which == 0) begin
         for (int k = 0; k < nt0; k++) if (n - k >= 0) acc += taps0[k] * hist[n-k];
         return acc;
      end
      for (int k = 0; k < nt1; k++) if (n - k >= 0) acc += taps1[k] * hist[n-k];
      return acc >>> 3;
   endfunction

   // output monitor: compares every output with the direct convolution
   always @(negedge clk) begin
      if (!rst) begin
         if (out_vld0) begin
            chk(int'($signed(out0)) == model(0, oidx0), "R2 u0 sample",
                int'($signed(out0)), model(0, oidx0));
            if (oidx0 < 64) got0[oidx0] = int'($signed(out0));
            last0 = int'($signed(out0));
            oidx0++;
         end else begin
            chk(out0 == prev0, "R4 u0 hold", int'($signed(out0)), int'($signed(prev0)));
         end
         if (out_vld1) begin
            chk(int'($signed(out1)) == model(1, oidx1), "R7 u1 sample",
                int'($signed(out1)), model(1, oidx1));
            last1 = int'($signed(out1));
            oidx1++;
         end else begin
            chk(out1 == prev1, "R4 u1 hold", int'($signed(out1)), int'($signed(prev1)));
         end
         prev0 = out0;
         prev1 = out1;
      end
   end

   task automatic push(input int v);
      @(negedge clk);
      in_vld = 1'b1;
      in_smp = v[7:0];
      hist[nidx] = v;
      nidx++;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_vld = 1'b0;
      @(posedge clk);
      #0.5;
      nidx = 0; oidx0 = 0; oidx1 = 0; prev0 = '0; prev1 = '0;
      @(negedge clk);
      // R1 reset state
      chk(!out_vld0 && out0 == '0, "R1 u0 reset", int'(out0), 0);
      chk(!out_vld1 && out1 == '0, "R1 u1 reset", int'(out1), 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      mk_taps('{3, 5, 3, 5}, 4, taps0, nt0);
      mk_taps('{2, 16, 2, 2}, 2, taps1, nt1);

      do_reset();

      // R3 latency: one sample, count cycles to out_vld
      push(5);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         in_vld = 1'b0;
         chk(out_vld0 == (k == 4), "R3 u0 latency", int'(out_vld0), int'(k == 4));
         if (k <= 2) chk(out_vld1 == (k == 2), "R3 u1 latency", int'(out_vld1), int'(k == 2));
      end
      idle(20);

      // R2 table walk: impulse response against hand taps
      do_reset();
      for (int i = 0; i < TBL_N; i++) push(TBL_IN[i]);
      idle(10);
      for (int i = 0; i < TBL_N; i++)
         chk(got0[i] == TBL_EXP[i], "R2 table tap", got0[i], TBL_EXP[i]);

      // R1 reset with samples in flight, then a clean impulse
      do_reset();
      for (int i = 0; i < 5; i++) push(90 - 40 * i);
      do_reset();
      push(1);
      for (int i = 0; i < 14; i++) push(0);
      idle(10);
      chk(oidx0 == 15, "R1 u0 clean count", oidx0, 15);

      // R5 DC gain
      do_reset();
      for (int i = 0; i < 30; i++) push(100);
      idle(10);
      chk(last0 == 22500, "R5 u0 dc", last0, 22500);
      chk(last1 == 400, "R5 u1 dc", last1, 400);

      // R6 full-scale streams
      do_reset();
      for (int i = 0; i < 30; i++) push(-128);
      idle(6);
      chk(last0 == -28800, "R6 u0 min", last0, -28800);
      chk(last1 == -512, "R6 u1 min", last1, -512);
      for (int i = 0; i < 30; i++) push(127);
      idle(6);
      chk(last0 == 28575, "R6 u0 max", last0, 28575);
      chk(last1 == 508, "R6 u1 max", last1, 508);
      for (int i = 0; i < 40; i++) push((i % 2 == 0) ? 127 : -128);
      idle(6);

      // R4 random idle gaps between samples
      do_reset();
      for (int i = 0; i < 60; i++) begin
         push($urandom_range(0, 255) - 128);
         idle($urandom_range(0, 3));
      end
      idle(10);
      chk(oidx0 == nidx, "R4 u0 one output per sample", oidx0, nidx);
      chk(oidx1 == nidx, "R4 u1 one output per sample", oidx1, nidx);

      // R7 floor rounding of small negative results
      do_reset();
      push(-1);
      for (int i = 0; i < 16; i++) push(0);
      idle(6);
      chk(last1 == -1, "R7 u1 floor", last1, -1);

      // R2 random full-rate stream
      do_reset();
      for (int i = 0; i < 200; i++) push($urandom_range(0, 255) - 128);
      idle(10);
      chk(oidx0 == 200, "R2 u0 stream count", oidx0, 200);

      done = 1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
      end
   end

endmodule